// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block is the digital sequencer for a 12-bit charge-redistribution successive-approximation converter. When a start request arrives, it first holds the capacitor array in the tracking position for a programmable number of sample cycles. It then resolves one code bit per clock, from the most significant bit down to the least. In each decision cycle it proposes the next bit as 1 and keeps or drops it according to a single comparator-result input.

The capacitor-array switch controls form two 6-bit segments. The upper segment carries code bits 11..6 and the lower segment carries bits 5..0. Within the upper segment, the three heaviest bits are not driven as binary-weighted switches. They are expanded into seven equal unit-switch lines, which keeps the DAC transfer monotonic. The remaining three upper bits and the six lower bits drive their switches directly.

A mode input moves the converter between a working state and a power-down state. In power-down the analog enable is dropped and every switch line is parked. Leaving power-down costs one settling cycle. Each completed conversion puts the final code on a registered output and raises a one-clock done strobe.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After a conversion, `code` equals the largest 12-bit value V for which the comparator reported the input above the DAC level of every trial whose code was not above V. With an input at value X, where the comparator returns 1 exactly when X >= DAC level, the result is X.
- R2: In each decision cycle the DAC level equals the bits already resolved plus the bit under test set to 1, with all lower bits 0. A comparator result of 1 keeps that bit and 0 clears it. The first trial is therefore 2048, which shows as 4 thermometer lines and zero on all other lines.
- R3: The second trial sets the level to 3/4 of full scale (6 thermometer lines) when the MSB resolved to 1, and to 1/4 of full scale (2 thermometer lines) when it resolved to 0. All binary lines stay 0 in that trial.
- R4: `therm_sw[k]` is 1 exactly when k is less than trial bits 11..9 read as an unsigned number, so the lowest-indexed lines assert first. `hi_bin_sw[2:0]` carries trial bits 8..6, and `lo_sw[5:0]` carries trial bits 5..0. The DAC level is (ones in therm_sw)*512 + hi_bin_sw*64 + lo_sw.
- R5: `done` is high for exactly one clock. It rises at the edge that comes SAMPLE_CYCLES+12 edges after the edge that accepted `start`. `code` changes only at that edge and holds until the next done.
- R6: During sampling, `samp_en` is high for exactly SAMPLE_CYCLES cycles, starting from the edge that accepts `start`. During those cycles every switch line is 0 and `busy` is high.
- R7: A `start` that arrives while a conversion is in progress is ignored. The running conversion finishes on its original schedule with the correct code.
- R8: While `pwr_up` is 0, from the next edge onward `afe_en`, `samp_en`, `busy` and all switch lines are 0. A conversion in progress is abandoned without a done strobe, and `start` is ignored.
- R9: `afe_en` rises at the first edge that samples `pwr_up` high. The next edge is a settling cycle in which `start` is ignored. A start is accepted from the edge after that.
- R10: Reset leaves the block in power-down with `afe_en`, `busy`, `samp_en` and `done` low, `code` zero and all switch lines zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up | input | 1 | 1 selects working mode, 0 selects power-down |
| start | input | 1 | Conversion request, sampled on rising edges |
| cmp_hi | input | 1 | Comparator result, 1 when the input exceeds the DAC level |
| afe_en | output | 1 | Analog front-end enable |
| samp_en | output | 1 | Array in tracking (sample) position |
| busy | output | 1 | Sampling or deciding |
| therm_sw | output | 7 | Unit-switch lines for the three heaviest bits |
| hi_bin_sw | output | 3 | Binary switch lines for bits 8..6 |
| lo_sw | output | 6 | Lower segment switch lines, bits 5..0 |
| code | output | 12 | Last conversion result |
| done | output | 1 | One-clock strobe when a new code is available |

## Verification
The checker assumes that `cmp_hi` settles within the cycle after the switch lines change. The bench meets this by deriving the comparator combinationally from the switch outputs through an ideal DAC model. The checker also assumes that `start` and `pwr_up` change only between edges, and the bench always drives them half a cycle or one nanosecond away from the rising edge. The power-down checks treat `afe_en` as the mode indicator, so the bench drops and raises `pwr_up` only as whole-cycle levels.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_WAKE = 3'd1,
    ST_IDLE = 3'd2,
    ST_SAMP = 3'd3,
    ST_CONV = 3'd4
  } sar_state_e;

  function automatic logic is_active(input sar_state_e s);
    return (s == ST_SAMP) || (s == ST_CONV);
  endfunction

endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_ctrl_pkg::*;
#(
  parameter int BITS          = 12,
  parameter int SAMPLE_CYCLES = 2,
  localparam int IDXW         = $clog2(BITS),
  localparam int SCW          = $clog2(SAMPLE_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwr_up,
  input  logic            start,
  output logic [IDXW-1:0] bit_idx,
  output logic            enter_conv,
  output logic            decide,
  output logic            finish,
  output logic            samp_en,
  output logic            afe_en,
  output logic            busy
);

  sar_state_e state, state_nxt;
  logic [SCW-1:0] scnt;
  logic           samp_last;
  logic           bit_last;

  assign samp_last = (scnt == SCW'(SAMPLE_CYCLES - 1));
  assign bit_last  = (bit_idx == '0);

  always_comb begin
    state_nxt = state;
    if (!pwr_up) begin
      state_nxt = ST_OFF;
    end else begin
      case (state)
        ST_OFF:  state_nxt = ST_WAKE;
        ST_WAKE: state_nxt = ST_IDLE;
        ST_IDLE: if (start) state_nxt = ST_SAMP;
        ST_SAMP: if (samp_last) state_nxt = ST_CONV;
        ST_CONV: if (bit_last) state_nxt = ST_IDLE;
        default: state_nxt = ST_OFF;
      endcase
    end
  end

  // Strobes consumed by the trial register in the current cycle
  assign enter_conv = (state == ST_SAMP) && (state_nxt == ST_CONV);
  assign decide     = (state == ST_CONV) && pwr_up;
  assign finish     = decide && bit_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OFF;
    end else begin
      state <= state_nxt;
    end
  end

  // Sample-phase length counter
  always_ff @(posedge clk) begin
    if (rst) begin
      scnt <= '0;
    end else if (state_nxt == ST_SAMP && state == ST_SAMP) begin
      scnt <= scnt + SCW'(1);
    end else begin
      scnt <= '0;
    end
  end

  // Bit under test
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx <= '0;
    end else if (enter_conv) begin
      bit_idx <= IDXW'(BITS - 1);
    end else if (decide && !bit_last) begin
      bit_idx <= bit_idx - IDXW'(1);
    end else if (state_nxt != ST_CONV) begin
      bit_idx <= '0;
    end
  end

  // Registered mode outputs, decoded from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      samp_en <= 1'b0;
      afe_en  <= 1'b0;
      busy    <= 1'b0;
    end else begin
      samp_en <= (state_nxt == ST_SAMP);
      afe_en  <= (state_nxt != ST_OFF);
      busy    <= is_active(state_nxt);
    end
  end

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int BITS  = 12,
  localparam int IDXW = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enter_conv,
  input  logic            decide,
  input  logic            finish,
  input  logic [IDXW-1:0] bit_idx,
  input  logic            cmp_hi,
  output logic [BITS-1:0] trial_nxt,
  output logic [BITS-1:0] resolved
);

  logic [BITS-1:0] trial;

  // Settle the bit under test and propose the next lower one
  always_comb begin
    resolved = trial;
    for (int k = 0; k < BITS; k++) begin
      if (IDXW'(k) == bit_idx) resolved[k] = cmp_hi;
    end
  end

  always_comb begin
    trial_nxt = '0;
    if (enter_conv) begin
      trial_nxt = '0;
      trial_nxt[BITS-1] = 1'b1;
    end else if (decide && !finish) begin
      trial_nxt = resolved;
      for (int k = 0; k < BITS - 1; k++) begin
        if (IDXW'(k + 1) == bit_idx) trial_nxt[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trial <= '0;
    end else begin
      trial <= trial_nxt;
    end
  end

endmodule

// File: rtl/sar_therm_dec.sv
module sar_therm_dec #(
  parameter int TBITS  = 3,
  localparam int LINES = (1 << TBITS) - 1
) (
  input  logic [TBITS-1:0] value,
  output logic [LINES-1:0] lines
);

  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign lines[k] = (value > TBITS'(k));
  end

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int BITS          = 12,
  parameter int SEG_BITS      = 6,
  parameter int THERM_BITS    = 3,
  parameter int SAMPLE_CYCLES = 2,
  localparam int THERM_LINES  = (1 << THERM_BITS) - 1,
  localparam int HI_BIN       = SEG_BITS - THERM_BITS,
  localparam int LO_BITS      = BITS - SEG_BITS,
  localparam int IDXW         = $clog2(BITS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pwr_up,
  input  logic                   start,
  input  logic                   cmp_hi,
  output logic                   afe_en,
  output logic                   samp_en,
  output logic                   busy,
  output logic [THERM_LINES-1:0] therm_sw,
  output logic [HI_BIN-1:0]      hi_bin_sw,
  output logic [LO_BITS-1:0]     lo_sw,
  output logic [BITS-1:0]        code,
  output logic                   done
);

  logic [IDXW-1:0]        bit_idx;
  logic                   enter_conv;
  logic                   decide;
  logic                   finish;
  logic [BITS-1:0]        trial_nxt;
  logic [BITS-1:0]        resolved;
  logic [THERM_LINES-1:0] therm_nxt;

  sar_seq_fsm #(
    .BITS          (BITS),
    .SAMPLE_CYCLES (SAMPLE_CYCLES)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .pwr_up     (pwr_up),
    .start      (start),
    .bit_idx    (bit_idx),
    .enter_conv (enter_conv),
    .decide     (decide),
    .finish     (finish),
    .samp_en    (samp_en),
    .afe_en     (afe_en),
    .busy       (busy)
  );

  sar_trial_reg #(
    .BITS (BITS)
  ) u_trial (
    .clk        (clk),
    .rst        (rst),
    .enter_conv (enter_conv),
    .decide     (decide),
    .finish     (finish),
    .bit_idx    (bit_idx),
    .cmp_hi     (cmp_hi),
    .trial_nxt  (trial_nxt),
    .resolved   (resolved)
  );

  sar_therm_dec #(
    .TBITS (THERM_BITS)
  ) u_therm (
    .value (trial_nxt[BITS-1 -: THERM_BITS]),
    .lines (therm_nxt)
  );

  // Switch lines registered from the next trial word
  always_ff @(posedge clk) begin
    if (rst) begin
      therm_sw  <= '0;
      hi_bin_sw <= '0;
      lo_sw     <= '0;
    end else begin
      therm_sw  <= therm_nxt;
      hi_bin_sw <= trial_nxt[LO_BITS +: HI_BIN];
      lo_sw     <= trial_nxt[LO_BITS-1:0];
    end
  end

  // Result capture and completion strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
      done <= 1'b0;
    end else begin
      done <= finish;
      if (finish) code <= resolved;
    end
  end

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int THERM_LINES = 7,
  parameter int HI_BIN      = 3,
  parameter int LO_BITS     = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   afe_en,
  input logic                   samp_en,
  input logic                   busy,
  input logic [THERM_LINES-1:0] therm_sw,
  input logic [HI_BIN-1:0]      hi_bin_sw,
  input logic [LO_BITS-1:0]     lo_sw,
  input logic                   done
);

  logic sw_zero;
  assign sw_zero = (therm_sw == '0) && (hi_bin_sw == '0) && (lo_sw == '0);

  // R4
  therm_contig_chk: assert property (@(posedge clk) disable iff (rst)
    (therm_sw & (therm_sw + THERM_LINES'(1))) == '0);

  // R8
  pd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !afe_en |-> (!busy && !samp_en && sw_zero && !done));

  // R6
  samp_parked_chk: assert property (@(posedge clk) disable iff (rst)
    samp_en |-> (sw_zero && busy && afe_en));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && afe_en));

  // R7
  start_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(samp_en) |-> $past(!busy));

  // R9
  wake_settle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(afe_en) |=> !busy);

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
  .THERM_LINES (THERM_LINES),
  .HI_BIN      (HI_BIN),
  .LO_BITS     (LO_BITS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .afe_en    (afe_en),
  .samp_en   (samp_en),
  .busy      (busy),
  .therm_sw  (therm_sw),
  .hi_bin_sw (hi_bin_sw),
  .lo_sw     (lo_sw),
  .done      (done)
);

// File: tb/sar_conv_ctrl_bench.sv
`timescale 1ns/1ps
module sar_conv_ctrl_bench;

  localparam int S = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_up = 1'b0;
  logic start = 1'b0;
  logic cmp_hi;
  logic afe_en, samp_en, busy, done;
  logic [6:0]  therm_sw;
  logic [2:0]  hi_bin_sw;
  logic [5:0]  lo_sw;
  logic [11:0] code;
  int vin = 0;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sar_conv_ctrl #(.SAMPLE_CYCLES(S)) u_sar_conv_ctrl (
    .clk(clk), .rst(rst), .pwr_up(pwr_up), .start(start), .cmp_hi(cmp_hi),
    .afe_en(afe_en), .samp_en(samp_en), .busy(busy), .therm_sw(therm_sw),
    .hi_bin_sw(hi_bin_sw), .lo_sw(lo_sw), .code(code), .done(done)
  );

  // Ideal DAC and comparator model
  int dac;
  assign dac = $countones(therm_sw) * 512 + int'(hi_bin_sw) * 64 + int'(lo_sw);
  assign cmp_hi = (vin >= dac);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit sw_zero();
    return therm_sw == 0 && hi_bin_sw == 0 && lo_sw == 0;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(afe_en == 0 && busy == 0 && samp_en == 0, "R10 mode outputs", afe_en, 0);
    check(done == 0 && code == 0, "R10 code/done", code, 0);
    check(sw_zero(), "R10 switches", dac, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_wake();
    @(negedge clk);
    pwr_up = 1'b1;
    start = 1'b1;
    @(posedge clk); #1;
    check(afe_en == 1, "R9 afe_en after wake edge", afe_en, 1);
    check(busy == 0, "R9 no start on wake edge", busy, 0);
    @(posedge clk); #1;
    check(busy == 0, "R9 start ignored in settle cycle", busy, 0);
    start = 1'b0;
    @(posedge clk); #1;
    check(busy == 0 && samp_en == 0, "R9 idle without start", busy, 0);
  endtask

  task automatic t_convert(input int v, input bit inject);
    int n = 0;
    int samp_cnt = 0;
    int exp_two;
    vin = v;
    @(negedge clk);
    start = 1'b1;
    while (done !== 1'b1 && n < 60) begin
      @(posedge clk); #1;
      n++;
      start = (inject && n == 5) ? 1'b1 : 1'b0;
      if (samp_en) begin
        samp_cnt++;
        check(sw_zero(), "R6 switches parked while sampling", dac, 0);
      end
      if (n == S + 1)
        check(therm_sw == 7'b0001111 && hi_bin_sw == 0 && lo_sw == 0,
              "R2 first trial level", dac, 2048);
      if (n == S + 2) begin
        exp_two = v[11] ? 6 : 2;
        check($countones(therm_sw) == exp_two && hi_bin_sw == 0 && lo_sw == 0,
              "R3 second trial lines", $countones(therm_sw), exp_two);
      end
      if (n == S + 12)
        check(dac == (v | 1) && therm_sw == 7'((1 << v[11:9]) - 1),
              "R4 last trial switch mapping", dac, v | 1);
      if (n > 1 && n <= S + 12 && !done)
        check(busy == 1, "R6 busy during conversion", busy, 1);
    end
    start = 1'b0;
    check(n == S + 13, "R5 done latency", n, S + 13);
    check(samp_cnt == S, "R6 sample cycle count", samp_cnt, S);
    check(int'(code) == v, inject ? "R7 code with extra start" : "R1 code", code, v);
    @(posedge clk); #1;
    check(done == 0, "R5 done one cycle", done, 0);
    @(posedge clk); #1;
    check(int'(code) == v && busy == 0, "R5 code holds", code, v);
  endtask

  task automatic t_power_abort();
    int n = 0;
    vin = 3000;
    @(negedge clk);
    start = 1'b1;
    repeat (6) begin
      @(posedge clk); #1;
      start = 1'b0;
      n++;
    end
    pwr_up = 1'b0;
    @(posedge clk); #1;
    check(afe_en == 0 && busy == 0 && samp_en == 0, "R8 power-down outputs", afe_en, 0);
    check(sw_zero(), "R8 switches parked", dac, 0);
    start = 1'b1;
    n = 0;
    repeat (20) begin
      @(posedge clk); #1;
      if (done || busy) n++;
    end
    start = 1'b0;
    check(n == 0, "R8 no done/start while off", n, 0);
    check(code != 12'(3000), "R8 abandoned code not posted", code, 0);
    @(negedge clk);
    pwr_up = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(afe_en == 1 && busy == 0, "R9 awake again", afe_en, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_wake();
    t_convert(0, 1'b0);
    t_convert(4095, 1'b0);
    t_convert(2048, 1'b0);
    t_convert(2047, 1'b0);
    t_convert(12'hA5C, 1'b0);
    t_convert(1, 1'b0);
    t_convert(1234, 1'b1);
    t_power_abort();
    t_convert(3071, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule